// File: doc/BRIEF.md
# Sign-Magnitude Complement Subtractor

This block subtracts an unsigned subtrahend from an unsigned minuend by complement addition and reports the difference as a sign bit plus a positive magnitude. A run-time mode input selects the method. In ones'-complement mode the subtrahend is inverted, added to the minuend, and any carry out of the top bit is folded back into the bottom bit. In two's-complement mode the subtrahend is inverted and incremented before the addition. In both modes the carry out of the top bit decides the sign and whether the sum has to be complemented again to recover the magnitude.

A caller presents both operands and the mode with a one-cycle strobe. One clock later the block raises its valid flag for one cycle with the sign and magnitude. Those outputs then hold until the next strobe. The subtrahend port may be narrower than the minuend. It is zero-extended before it is complemented.

Top module: `cmpl_subtractor`

## Requirements
- R1: When the subtrahend width SUB_W is smaller than the minuend width DATA_W, the subtrahend is treated as zero-extended to DATA_W bits, so the result is the difference of the two unsigned values.
- R2: With `mode_twos` = 0 (ones'-complement mode), the minuend is added to the bitwise inverse of the subtrahend. If that addition carries out of the top bit, the carry is added back into the bottom bit and the result is positive (`out_neg` = 0, `out_mag` = minuend − subtrahend).
- R3: In ones'-complement mode with no carry out, the result is negative (`out_neg` = 1) and `out_mag` is the bitwise inverse of the sum, which equals subtrahend − minuend.
- R4: With `mode_twos` = 1 (two's-complement mode), the inverted subtrahend is incremented by one before the addition. A carry out gives a positive result whose magnitude is the sum.
- R5: In two's-complement mode with no carry out, the result is negative and `out_mag` is the two's complement of the sum.
- R6: A zero difference is always reported with `out_neg` = 0 in both modes, including equal operands in ones'-complement mode, where the sum is all ones.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low in every other cycle.
- R8: `out_mag` and `out_neg` change only on the clock edge that samples `in_valid` high. They hold their values otherwise, whatever the operand and mode inputs do.
- R9: While `rst_n` is low, `out_valid`, `out_neg` and `out_mag` are all 0.
- R10: With 5-bit operands, 10110 − 01010 gives positive 01100 and 11010 − 11110 gives negative 00100, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: operands and mode are sampled on this edge |
| mode_twos | input | 1 | 0 = ones'-complement method, 1 = two's-complement method |
| minuend | input | DATA_W | Unsigned minuend |
| subtrahend | input | SUB_W | Unsigned subtrahend, zero-extended to DATA_W |
| out_valid | output | 1 | One-cycle pulse one clock after the strobe |
| out_neg | output | 1 | Sign of the difference, 1 = negative |
| out_mag | output | DATA_W | Magnitude of the difference |

## Verification
On every cycle the assertions check the timing of the valid pulse, that the outputs hold between strobes, that a zero magnitude never carries a negative sign, and that the sign follows the adder's carry in each mode: a carry in ones' mode gives a positive result, and no carry in two's mode gives a negative one. Whether the magnitude is numerically right can only be shown by the bench. It compares against an integer difference over directed cases (the worked 5-bit examples, equal operands in both modes, the extremes of the zero-extended subtrahend) and a long stream of mixed strobed and idle cycles in both modes.

// File: rtl/csub_pkg.sv
package csub_pkg;

  typedef enum logic {
    CSUB_ONES = 1'b0,
    CSUB_TWOS = 1'b1
  } csub_mode_e;

  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // One shared +1 covers both cases: the end-around carry (ones', carry set)
  // and the recomplement of a negative sum (twos', carry clear).
  function automatic logic incr_enable(input logic carry, input csub_mode_e mode);
    return (mode == CSUB_TWOS) ? !carry : carry;
  endfunction

endpackage

// File: rtl/csub_complementer.sv
module csub_complementer #(
  parameter int DATA_W = 8,
  parameter int SUB_W  = 8
) (
  input  logic [SUB_W-1:0]  sub_in,
  output logic [DATA_W-1:0] sub_inv
);
  localparam int PAD_W = DATA_W - SUB_W;

  logic [DATA_W-1:0] sub_ext;

  if (PAD_W > 0) begin : g_pad
    assign sub_ext = {{PAD_W{1'b0}}, sub_in};
  end else begin : g_nopad
    assign sub_ext = sub_in;
  end

  assign sub_inv = ~sub_ext;
endmodule

// File: rtl/csub_adder.sv
module csub_adder
  import csub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = fa_sum(a[i], b[i], chain[i]);
    assign chain[i+1] = fa_carry(a[i], b[i], chain[i]);
  end

  assign cout = chain[W];
endmodule

// File: rtl/csub_resolver.sv
module csub_resolver
  import csub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] raw_sum,
  input  logic         raw_carry,
  input  csub_mode_e   mode,
  output logic [W-1:0] mag,
  output logic         neg,
  output logic         inc_en
);
  logic [W-1:0] inc_base;
  logic         is_zero;

  always_comb begin
    inc_en   = incr_enable(raw_carry, mode);
    // no carry means a negative result: flip the sum before the optional +1
    inc_base = raw_carry ? raw_sum : ~raw_sum;
    mag      = inc_base + W'(inc_en);
    is_zero  = (mag == '0);
    neg      = !raw_carry && !is_zero;
  end
endmodule

// File: rtl/cmpl_subtractor.sv
module cmpl_subtractor
  import csub_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SUB_W  = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              mode_twos,
  input  logic [DATA_W-1:0] minuend,
  input  logic [SUB_W-1:0]  subtrahend,
  output logic              out_valid,
  output logic              out_neg,
  output logic [DATA_W-1:0] out_mag
);
  csub_mode_e        mode_sel;
  logic [DATA_W-1:0] sub_inv;
  logic              add_cin;
  logic [DATA_W-1:0] add_sum;
  logic              add_carry;
  logic [DATA_W-1:0] res_mag;
  logic              res_neg;
  logic              end_fix;

  assign mode_sel = csub_mode_e'(mode_twos);
  // the two's-complement +1 rides on the adder's carry-in
  assign add_cin  = (mode_sel == CSUB_TWOS);

  csub_complementer #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_compl (
    .sub_in (subtrahend),
    .sub_inv(sub_inv)
  );

  csub_adder #(.W(DATA_W)) u_add (
    .a   (minuend),
    .b   (sub_inv),
    .cin (add_cin),
    .sum (add_sum),
    .cout(add_carry)
  );

  csub_resolver #(.W(DATA_W)) u_res (
    .raw_sum  (add_sum),
    .raw_carry(add_carry),
    .mode     (mode_sel),
    .mag      (res_mag),
    .neg      (res_neg),
    .inc_en   (end_fix)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_neg   <= 1'b0;
      out_mag   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_neg <= res_neg;
        out_mag <= res_mag;
      end
    end
  end
endmodule

// File: rtl/csub_checker.sv
module csub_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              mode_twos,
  input logic              add_carry,
  input logic              end_fix,
  input logic              out_valid,
  input logic              out_neg,
  input logic [DATA_W-1:0] out_mag
);
  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_between_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_mag) && $stable(out_neg)));

  assert_zero_positive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mag == '0) |-> !out_neg);

  assert_ones_carry_positive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode_twos && add_carry) |=> !out_neg);

  assert_ones_nocarry_negative_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode_twos && !add_carry) |=> (out_neg || out_mag == '0));

  assert_twos_carry_positive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_twos && add_carry) |=> !out_neg);

  assert_twos_nocarry_negative_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_twos && !add_carry) |=> out_neg);

  // the +1 is used exactly when ones' mode carries or two's mode does not
  assert_fix_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (end_fix == (mode_twos ^ add_carry)));
endmodule

bind cmpl_subtractor csub_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .mode_twos(mode_twos),
  .add_carry(add_carry),
  .end_fix  (end_fix),
  .out_valid(out_valid),
  .out_neg  (out_neg),
  .out_mag  (out_mag)
);

// File: tb/cmpl_subtractor_bench.sv
module cmpl_subtractor_bench;
  localparam int CLK_P  = 10;
  localparam int DW     = 8;
  localparam int SW     = 5;
  localparam int WD_CYC = 200000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          mode_twos;
  logic [DW-1:0] minuend;
  logic [SW-1:0] subtrahend;
  logic          out_valid;
  logic          out_neg;
  logic [DW-1:0] out_mag;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    finished = 1'b0;

  int    exp_mag   = 0;
  bit    exp_neg   = 1'b0;
  bit    exp_valid = 1'b0;
  string exp_tag   = "R9";

  always #(CLK_P/2) clk = ~clk;

  cmpl_subtractor #(.DATA_W(DW), .SUB_W(SW)) u_cmpl_subtractor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_twos(mode_twos),
    .minuend(minuend), .subtrahend(subtrahend),
    .out_valid(out_valid), .out_neg(out_neg), .out_mag(out_mag)
  );

  task automatic check_now();
    n_checks++;
    if (out_valid !== exp_valid) begin
      n_errors++;
      $display("FAIL R7 out_valid actual=%0b expected=%0b", out_valid, exp_valid);
    end
    n_checks++;
    if (int'(out_mag) != exp_mag || out_neg !== exp_neg) begin
      n_errors++;
      $display("FAIL %s result actual=%0s%0d expected=%0s%0d", exp_tag,
               out_neg ? "-" : "+", out_mag, exp_neg ? "-" : "+", exp_mag);
    end
  endtask

  // behavioural reference: integer difference of the sampled inputs
  task automatic step();
    int d;
    @(posedge clk);
    exp_valid = in_valid;
    if (in_valid) begin
      d       = int'(minuend) - int'(subtrahend);
      exp_neg = (d < 0);
      exp_mag = (d < 0) ? -d : d;
      if (d == 0)      exp_tag = "R6";
      else if (d > 0)  exp_tag = mode_twos ? "R4" : "R2";
      else             exp_tag = mode_twos ? "R5" : "R3";
      if (int'(subtrahend) > 15 && d != 0) exp_tag = {exp_tag, "/R1"};
    end else begin
      exp_tag = "R8";
    end
    @(negedge clk);
    check_now();
  endtask

  task automatic put(input logic v, input logic m, input logic [DW-1:0] a,
                     input logic [SW-1:0] b);
    in_valid = v; mode_twos = m; minuend = a; subtrahend = b;
    step();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * WD_CYC);
    n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; mode_twos = 1'b0; minuend = '0; subtrahend = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    exp_tag = "R9";
    check_now();                       // R9 reset state
    rst_n = 1'b1;
    step();                            // idle after reset: still zero (R8)

    // R10 worked examples, both modes
    put(1, 0, 8'b00010110, 5'b01010);  // +12 (R2)
    put(1, 1, 8'b00010110, 5'b01010);  // +12 (R4)
    put(1, 0, 8'b00011010, 5'b11110);  // -4  (R3)
    put(1, 1, 8'b00011010, 5'b11110);  // -4  (R5)
    // R6 equal operands in both modes, and all-zero
    put(1, 0, 8'd19, 5'd19);
    put(1, 1, 8'd19, 5'd19);
    put(1, 0, 8'd0, 5'd0);
    put(1, 1, 8'd0, 5'd0);
    // R1 zero extension extremes
    put(1, 0, 8'd255, 5'd31);
    put(1, 1, 8'd0, 5'd31);
    put(1, 0, 8'd0, 5'd31);
    put(1, 1, 8'd31, 5'd31);
    // R8 hold: negative result, then idle cycles with busy inputs
    put(1, 1, 8'd3, 5'd30);
    put(0, 0, 8'd200, 5'd1);
    put(0, 1, 8'd7, 5'd7);
    put(0, 0, 8'd0, 5'd9);
    // R7 back-to-back strobes
    put(1, 0, 8'd128, 5'd1);
    put(1, 1, 8'd1, 5'd2);
    put(0, 0, 8'd1, 5'd2);

    for (int i = 0; i < 400; i++) begin
      put(($urandom % 4) != 0, $urandom % 2, DW'($urandom), SW'($urandom));
    end
    put(0, 0, 8'd0, 5'd0);
    finish_run();
  end
endmodule